// File: doc/BRIEF.md
# Unlock-Guarded Flash Erase and Write Controller

This block is the control front end for on-chip flash erase and program operations. Software reaches it over a simple byte-wide register bus. It holds a mode register, a separate key register and a byte-addressed table pointer. Erase and program operations are dangerous if they fire by accident, so the start bit is only honoured under three conditions. The key register must first receive 55h and then AAh. The start write must follow those two key writes with no bus access of any kind in between. Write enable must already be set.

When an operation is accepted, the block latches its attributes: erase or program, code or configuration space, and the target block address. For an erase the address is the 64-byte block that holds the pointer. For a program it is the 8-byte row that holds the pointer. After a fixed start delay the block presents a request to the flash array. It holds that request until the array signals completion, and then it clears the start bit.

Top module: `flash_guard_ctrl`

## Requirements
- R1: After reset the mode register (bus_sel 0) reads 00h, the block is locked and flash_req is low.
- R2: In the mode register, bit 7 selects code space, bit 6 selects configuration space, bit 4 selects erase (0 selects program) and bit 2 is write enable. Bit 1 is the start bit, which reads 1 only while an operation is in flight. Bits 0, 3 and 5 always read 0. The pointer bytes are at bus_sel 2, 3 and 4, least significant first.
- R3: A write of 55h to the key register (bus_sel 1), then a write of AAh to it, followed at once by a mode write with bit 1 set, launches an operation.
- R4: Any other bus access breaks the sequence and re-locks the block. This includes a read, a pointer write or a mode write, occurring either between the two key writes or between the second key write and the start write. An unlocked start bit is ignored and reads back 0.
- R5: Launch requires write enable to be 1 already in the register and bit 2 to be set in the start write. Otherwise no request is issued.
- R6: Bit 7 = 1 with bit 6 = 0 targets code space (flash_cfg = 0). Bit 6 = 1 targets configuration space (flash_cfg = 1). If both bits are 0 the start is ignored.
- R7: flash_req rises START_DLY clock edges (default 4) after the edge that takes the launching write.
- R8: An erase drives flash_erase = 1 and flash_addr = pointer with its low 6 bits cleared. A program drives flash_erase = 0 and flash_addr = pointer with its low 3 bits cleared.
- R9: flash_req stays high with a stable address until flash_done is sampled high. On that edge it drops, and the start bit reads 0 afterwards.
- R10: While an operation is in flight, the start bit reads 1 and mode writes change only write enable. Pointer writes do not alter flash_addr. flash_done is ignored when no request is pending.
- R11: A fully unlocked start write that falls in the same cycle as flash_done is ignored and consumes the unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 3 | Register select: 0 mode, 1 key, 2..4 pointer bytes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| flash_req | output | 1 | Operation request to the flash array |
| flash_erase | output | 1 | 1 = erase, 0 = program |
| flash_cfg | output | 1 | 1 = configuration space, 0 = code space |
| flash_addr | output | PTR_W | Aligned target address |
| flash_done | input | 1 | Completion pulse from the flash array |

## Verification
Two functions can land on the same edge: completion of the running operation, and acceptance of a new, fully unlocked start write. The bench sets up this collision on purpose. While a request is pending, it writes both key values. It then drives the start write in the same cycle as the flash_done pulse. The outcome passes only if the request drops, no new request appears over the following start-delay window, the start bit reads 0 and write enable reads 1.

// File: rtl/fgc_pkg.sv
package fgc_pkg;

    localparam logic [2:0] SEL_MODE = 3'd0;
    localparam logic [2:0] SEL_KEY  = 3'd1;
    localparam logic [2:0] SEL_PTR0 = 3'd2;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    localparam int BIT_CODE  = 7;
    localparam int BIT_CFG   = 6;
    localparam int BIT_ERASE = 4;
    localparam int BIT_WREN  = 2;
    localparam int BIT_START = 1;

    typedef enum logic [1:0] {
        UL_LOCKED = 2'd0,
        UL_HALF   = 2'd1,
        UL_ARMED  = 2'd2
    } unlock_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_REQ  = 2'd2
    } phase_e;

    typedef struct packed {
        logic code;
        logic cfg;
        logic erase;
        logic wren;
    } mode_t;

endpackage

// File: rtl/fgc_unlock.sv
module fgc_unlock
    import fgc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_valid,
    input  logic       bus_write,
    input  logic [2:0] bus_sel,
    input  logic [7:0] bus_wdata,
    output logic       armed
);

    typedef struct packed {
        unlock_e st;
    } ul_state_t;

    ul_state_t s_d, s_q;
    logic key_wr;

    always_comb begin
        s_d    = s_q;
        key_wr = bus_valid && bus_write && (bus_sel == SEL_KEY);
        if (bus_valid) begin
            if (key_wr && bus_wdata == KEY_FIRST) begin
                s_d.st = UL_HALF;
            end else if (key_wr && bus_wdata == KEY_SECOND && s_q.st == UL_HALF) begin
                s_d.st = UL_ARMED;
            end else begin
                s_d.st = UL_LOCKED;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st <= UL_LOCKED;
        end else begin
            s_q <= s_d;
        end
    end

    assign armed = (s_q.st == UL_ARMED);

    // R4: any access that is not a key write leaves the block locked
    p_access_relocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !(bus_write && bus_sel == SEL_KEY)) |=> !armed);

    // R3: arming only follows a key write
    p_arm_needs_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(bus_valid && bus_write && bus_sel == SEL_KEY));

endmodule

// File: rtl/fgc_ctrl_reg.sv
module fgc_ctrl_reg
    import fgc_pkg::*;
#(
    parameter int PTR_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [2:0]       bus_sel,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic             armed,
    input  logic             busy,
    output logic             launch,
    output logic             launch_erase,
    output logic             launch_cfg,
    output logic [PTR_W-1:0] ptr
);

    localparam int PTR_BYTES = (PTR_W + 7) / 8;

    typedef struct packed {
        mode_t            mode;
        logic [PTR_W-1:0] ptr;
    } reg_state_t;

    reg_state_t r_d, r_q;
    logic       mode_wr;
    logic       start_req;
    logic       target_ok;
    logic [2:0] ptr_idx;

    always_comb begin
        r_d       = r_q;
        mode_wr   = bus_valid && bus_write && (bus_sel == SEL_MODE);
        ptr_idx   = bus_sel - SEL_PTR0;
        start_req = mode_wr && bus_wdata[BIT_START];
        target_ok = bus_wdata[BIT_CFG] || bus_wdata[BIT_CODE];
        launch    = start_req && armed && !busy && r_q.mode.wren
                    && bus_wdata[BIT_WREN] && target_ok;

        if (mode_wr) begin
            if (busy) begin
                r_d.mode.wren = bus_wdata[BIT_WREN];
            end else begin
                r_d.mode.code  = bus_wdata[BIT_CODE];
                r_d.mode.cfg   = bus_wdata[BIT_CFG];
                r_d.mode.erase = bus_wdata[BIT_ERASE];
                r_d.mode.wren  = bus_wdata[BIT_WREN];
            end
        end

        if (bus_valid && bus_write && bus_sel >= SEL_PTR0
            && int'(ptr_idx) < PTR_BYTES) begin
            for (int b = 0; b < PTR_W; b++) begin
                if (int'(ptr_idx) == b / 8) begin
                    r_d.ptr[b] = bus_wdata[b % 8];
                end
            end
        end

        bus_rdata = 8'h00;
        if (bus_sel == SEL_MODE) begin
            bus_rdata[BIT_CODE]  = r_q.mode.code;
            bus_rdata[BIT_CFG]   = r_q.mode.cfg;
            bus_rdata[BIT_ERASE] = r_q.mode.erase;
            bus_rdata[BIT_WREN]  = r_q.mode.wren;
            bus_rdata[BIT_START] = busy;
        end else if (bus_sel >= SEL_PTR0 && int'(ptr_idx) < PTR_BYTES) begin
            for (int b = 0; b < PTR_W; b++) begin
                if (int'(ptr_idx) == b / 8) begin
                    bus_rdata[b % 8] = r_q.ptr[b];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign launch_erase = bus_wdata[BIT_ERASE];
    assign launch_cfg   = bus_wdata[BIT_CFG];
    assign ptr          = r_q.ptr;

    // R10: mode attributes other than write enable are frozen while busy
    p_mode_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(r_q.mode.erase) && $stable(r_q.mode.cfg)));

endmodule

// File: rtl/fgc_op_seq.sv
module fgc_op_seq
    import fgc_pkg::*;
#(
    parameter int PTR_W     = 22,
    parameter int START_DLY = 4,
    parameter int ERASE_LG  = 6,
    parameter int PROG_LG   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             launch_erase,
    input  logic             launch_cfg,
    input  logic [PTR_W-1:0] ptr,
    input  logic             flash_done,
    output logic             busy,
    output logic             flash_req,
    output logic             flash_erase,
    output logic             flash_cfg,
    output logic [PTR_W-1:0] flash_addr
);

    localparam int CNT_W = (START_DLY < 2) ? 1 : $clog2(START_DLY);
    localparam logic [PTR_W-1:0] ERASE_MASK = {{(PTR_W-ERASE_LG){1'b1}}, {ERASE_LG{1'b0}}};
    localparam logic [PTR_W-1:0] PROG_MASK  = {{(PTR_W-PROG_LG){1'b1}}, {PROG_LG{1'b0}}};

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic             erase;
        logic             cfg;
        logic [PTR_W-1:0] addr;
    } seq_state_t;

    seq_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (launch) begin
                    s_d.ph    = PH_WAIT;
                    s_d.cnt   = CNT_W'(START_DLY - 1);
                    s_d.erase = launch_erase;
                    s_d.cfg   = launch_cfg;
                    s_d.addr  = launch_erase ? (ptr & ERASE_MASK) : (ptr & PROG_MASK);
                end
            end
            PH_WAIT: begin
                if (s_q.cnt == '0) begin
                    s_d.ph = PH_REQ;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_REQ: begin
                if (flash_done) begin
                    s_d.ph = PH_IDLE;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy        = (s_q.ph != PH_IDLE);
    assign flash_req   = (s_q.ph == PH_REQ);
    assign flash_erase = s_q.erase;
    assign flash_cfg   = s_q.cfg;
    assign flash_addr  = s_q.addr;

    // R9: request held until completion
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_req && !flash_done) |=> flash_req);

    // R9: address stable while request pending
    p_addr_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_req && !flash_done) |=> $stable(flash_addr));

    // R9: completion ends the operation
    p_done_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_req && flash_done) |=> !busy);

endmodule

// File: rtl/flash_guard_ctrl.sv
module flash_guard_ctrl
    import fgc_pkg::*;
#(
    parameter int PTR_W     = 22,
    parameter int START_DLY = 4,
    parameter int ERASE_LG  = 6,
    parameter int PROG_LG   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [2:0]       bus_sel,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    output logic             flash_req,
    output logic             flash_erase,
    output logic             flash_cfg,
    output logic [PTR_W-1:0] flash_addr,
    input  logic             flash_done
);

    logic             armed;
    logic             busy;
    logic             launch;
    logic             launch_erase;
    logic             launch_cfg;
    logic [PTR_W-1:0] ptr;

    fgc_unlock u_unlock (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .armed     (armed)
    );

    fgc_ctrl_reg #(.PTR_W(PTR_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_valid    (bus_valid),
        .bus_write    (bus_write),
        .bus_sel      (bus_sel),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .armed        (armed),
        .busy         (busy),
        .launch       (launch),
        .launch_erase (launch_erase),
        .launch_cfg   (launch_cfg),
        .ptr          (ptr)
    );

    fgc_op_seq #(
        .PTR_W     (PTR_W),
        .START_DLY (START_DLY),
        .ERASE_LG  (ERASE_LG),
        .PROG_LG   (PROG_LG)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch       (launch),
        .launch_erase (launch_erase),
        .launch_cfg   (launch_cfg),
        .ptr          (ptr),
        .flash_done   (flash_done),
        .busy         (busy),
        .flash_req    (flash_req),
        .flash_erase  (flash_erase),
        .flash_cfg    (flash_cfg),
        .flash_addr   (flash_addr)
    );

    // R3: an operation starts only from an armed state
    p_busy_after_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(armed));

    // R11: no launch while an operation is still in flight
    p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !busy);

endmodule

// File: tb/flash_guard_ctrl_test.sv
module flash_guard_ctrl_test;

    localparam int PTR_W     = 22;
    localparam int START_DLY = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_valid = 1'b0;
    logic             bus_write = 1'b0;
    logic [2:0]       bus_sel = 3'd0;
    logic [7:0]       bus_wdata = 8'h00;
    logic [7:0]       bus_rdata;
    logic             flash_req;
    logic             flash_erase;
    logic             flash_cfg;
    logic [PTR_W-1:0] flash_addr;
    logic             flash_done = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done_run = 1'b0;

    always #5 clk = ~clk;

    flash_guard_ctrl #(.PTR_W(PTR_W), .START_DLY(START_DLY)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_valid   (bus_valid),
        .bus_write   (bus_write),
        .bus_sel     (bus_sel),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .flash_req   (flash_req),
        .flash_erase (flash_erase),
        .flash_cfg   (flash_cfg),
        .flash_addr  (flash_addr),
        .flash_done  (flash_done)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [2:0] sel, logic [7:0] data);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_sel = sel; bus_wdata = data;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic bus_rd(logic [2:0] sel, output logic [7:0] data);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_sel = sel;
        #1 data = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic set_ptr(logic [23:0] p);
        bus_wr(3'd2, p[7:0]);
        bus_wr(3'd3, p[15:8]);
        bus_wr(3'd4, p[23:16]);
    endtask

    task automatic keys();
        bus_wr(3'd1, 8'h55);
        bus_wr(3'd1, 8'hAA);
    endtask

    task automatic pulse_done();
        @(negedge clk);
        flash_done = 1'b1;
        @(negedge clk);
        flash_done = 1'b0;
    endtask

    task automatic expect_no_req(string req, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(req, {31'd0, flash_req}, 32'd0);
        end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        bus_rd(3'd0, d);
        check("R1 mode after reset", {24'd0, d}, 32'h00);
        check("R1 req after reset", {31'd0, flash_req}, 32'd0);
    endtask

    task automatic t_fields();
        logic [7:0] d;
        bus_wr(3'd0, 8'hFF);
        bus_rd(3'd0, d);
        check("R2 R4 field readback, start ignored", {24'd0, d}, 32'hD4);
        check("R4 no req unarmed", {31'd0, flash_req}, 32'd0);
        set_ptr(24'h0A5B7D);
        bus_rd(3'd3, d);
        check("R2 pointer byte1", {24'd0, d}, 32'h5B);
        bus_wr(3'd0, 8'h00);
        bus_rd(3'd0, d);
        check("R2 clear", {24'd0, d}, 32'h00);
    endtask

    task automatic t_erase_code();
        logic [7:0] d;
        set_ptr(24'h0A5B7D);
        bus_wr(3'd0, 8'h94);
        keys();
        bus_wr(3'd0, 8'h96);
        for (int i = 0; i < START_DLY - 1; i++) @(negedge clk);
        check("R7 req low before delay", {31'd0, flash_req}, 32'd0);
        @(negedge clk);
        check("R3 R7 req after delay", {31'd0, flash_req}, 32'd1);
        check("R8 erase flag", {31'd0, flash_erase}, 32'd1);
        check("R6 code space", {31'd0, flash_cfg}, 32'd0);
        check("R8 erase addr", {10'd0, flash_addr}, 32'h0A5B40);
        bus_rd(3'd0, d);
        check("R10 start reads 1 busy", {24'd0, d}, 32'h96);
        bus_wr(3'd2, 8'h00);
        bus_wr(3'd0, 8'h00);
        bus_rd(3'd0, d);
        check("R10 only wren writable", {24'd0, d}, 32'h92);
        check("R10 addr unaffected", {10'd0, flash_addr}, 32'h0A5B40);
        check("R9 req held", {31'd0, flash_req}, 32'd1);
        pulse_done();
        check("R9 req drops", {31'd0, flash_req}, 32'd0);
        bus_rd(3'd0, d);
        check("R9 start cleared", {24'd0, d}, 32'h90);
        pulse_done();
        check("R10 stray done ignored", {31'd0, flash_req}, 32'd0);
    endtask

    task automatic t_prog_cfg();
        set_ptr(24'h0A5B7D);
        bus_wr(3'd0, 8'h44);
        keys();
        bus_wr(3'd0, 8'h46);
        for (int i = 0; i < START_DLY; i++) @(negedge clk);
        check("R6 cfg req", {31'd0, flash_req}, 32'd1);
        check("R6 cfg space", {31'd0, flash_cfg}, 32'd1);
        check("R8 program flag", {31'd0, flash_erase}, 32'd0);
        check("R8 program addr", {10'd0, flash_addr}, 32'h0A5B78);
        pulse_done();
    endtask

    task automatic t_broken();
        logic [7:0] d;
        bus_wr(3'd0, 8'h84);
        bus_wr(3'd1, 8'h55);
        bus_rd(3'd0, d);
        bus_wr(3'd1, 8'hAA);
        bus_wr(3'd0, 8'h86);
        expect_no_req("R4 read between keys", START_DLY + 2);
        bus_rd(3'd0, d);
        check("R4 start reads 0", {24'd0, d}, 32'h84);
        keys();
        bus_wr(3'd2, 8'h11);
        bus_wr(3'd0, 8'h86);
        expect_no_req("R4 access before start", START_DLY + 2);
    endtask

    task automatic t_no_wren();
        bus_wr(3'd0, 8'h80);
        keys();
        bus_wr(3'd0, 8'h86);
        expect_no_req("R5 wren not preset", START_DLY + 2);
        keys();
        bus_wr(3'd0, 8'h82);
        expect_no_req("R5 wren cleared in start write", START_DLY + 2);
    endtask

    task automatic t_no_target();
        bus_wr(3'd0, 8'h04);
        keys();
        bus_wr(3'd0, 8'h06);
        expect_no_req("R6 no target", START_DLY + 2);
    endtask

    task automatic t_collide();
        logic [7:0] d;
        bus_wr(3'd0, 8'h94);
        keys();
        bus_wr(3'd0, 8'h96);
        for (int i = 0; i < START_DLY; i++) @(negedge clk);
        check("R11 setup req", {31'd0, flash_req}, 32'd1);
        keys();
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_sel = 3'd0; bus_wdata = 8'h96;
        flash_done = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; flash_done = 1'b0;
        check("R11 req dropped", {31'd0, flash_req}, 32'd0);
        expect_no_req("R11 no relaunch", START_DLY + 2);
        bus_rd(3'd0, d);
        check("R11 start 0 wren kept", {24'd0, d}, 32'h94);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fields();
        t_erase_code();
        t_prog_cfg();
        t_broken();
        t_no_wren();
        t_no_target();
        t_collide();
        done_run = 1'b1;
    end

    initial begin
        fork
            wait (done_run);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=hung expected=finished");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule